// File: doc/BRIEF.md
# Interrupt Flag and Pin Controller

This block gathers four event sources into a four-bit sticky flag register and one interrupt pin. The sources are a watchdog expiry, a time-of-day alarm match, a supply-drop detection and a century rollover. The alarm comparator is part of the block. On every 1 Hz time update it compares the current seconds, minutes, hours and date, all in BCD, against four alarm bytes. Each alarm byte has its own mask bit that removes its field from the match.

A flag latches whenever its event occurs, whatever the enables say. Only the sources whose enable is set can activate the pin. The pin is run by a state machine with three states: `PIN_IDLE`, `PIN_PULSE` and `PIN_HOLD`. In pulse mode a trigger moves the machine to `PIN_PULSE`, and it returns to `PIN_IDLE` after `PULSE_TICKS` ticks of the 32 Hz timebase. In level mode a trigger moves it to `PIN_HOLD`, and it returns to `PIN_IDLE` when the flag register is read. The machine resolves its transitions in this order:
- Calibration mode forces `PIN_IDLE`.
- A trigger from any state enters `PIN_PULSE` (counter restarted) or `PIN_HOLD`, depending on the mode.
- Otherwise the per-state exit applies.

In backup-power mode the watchdog and supply sources are switched off. The alarm can then reach the pin only through a separate backup enable, and the output is forced to open-drain active-low. In calibration mode the pin carries the incoming 512 Hz square wave.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `flags` is 0 and the pin state machine is in `PIN_IDLE`, so the pin is inactive.
- R2: Flag bits are WDF = bit 3 (watchdog), AF = bit 2 (alarm), PF = bit 1 (supply drop) and CF = bit 0 (century). Each bit is set on the clock edge that samples its event, whatever the enable inputs are.
- R3: A cycle with `flag_rd` high clears all four flags on that edge. An event sampled on the same edge still sets its flag.
- R4: A trigger comes only from an event whose enable (`en_wdog`, `en_alarm`, `en_pwr`) is 1. Without a trigger, an idle pin stays idle.
- R5: Outside calibration and backup, `act_high` = 1 gives a push-pull pin (`pin_oe` = 1, `pin_out` = active). `act_high` = 0 gives open-drain active-low (`pin_oe` = active, `pin_out` = 0).
- R6: With `pulse_mode` = 1, a trigger holds the pin active for exactly `PULSE_TICKS` (default 7) ticks of `tick_32hz`. A new trigger during the pulse restarts the count.
- R7: With `pulse_mode` = 0, a trigger holds the pin active until a cycle with `flag_rd` high that carries no new trigger.
- R8: An alarm event occurs on a `tick_1hz` cycle when every unmasked field matches. Each alarm byte has bit 7 = mask (1 ignores the field). Its value sits in bits 6:0 for seconds and minutes, and in bits 5:0 for hours and date, with bit 6 = 0.
- R9: A supply-drop event is the rising edge of the selected comparator input: `pwr_cmp_hi` when `thr_sel` = 1, `pwr_cmp_lo` when `thr_sel` = 0.
- R10: With `backup_mode` = 1:
  - watchdog and supply-drop events set no flag and cause no trigger;
  - the alarm triggers only if both `en_alarm` and `en_bkp_alarm` are 1;
  - the pin is open-drain active-low.
- R11: With `cal_mode` = 1, the state machine goes to `PIN_IDLE` and takes no trigger, and the pin is driven push-pull (`pin_oe` = 1) with `pin_out` = `sq512`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe at each time update |
| tick_32hz | input | 1 | One-cycle strobe of the 32 Hz timebase |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| alm_sec | input | 8 | Alarm seconds: bit 7 mask, 6:0 value |
| alm_min | input | 8 | Alarm minutes: bit 7 mask, 6:0 value |
| alm_hour | input | 8 | Alarm hours: bit 7 mask, 5:0 value |
| alm_date | input | 8 | Alarm date: bit 7 mask, 5:0 value |
| wdog_expire | input | 1 | Watchdog expiry strobe |
| century_wrap | input | 1 | Year rollover strobe |
| pwr_cmp_hi | input | 1 | Supply below the upper threshold |
| pwr_cmp_lo | input | 1 | Supply below the lower threshold |
| thr_sel | input | 1 | Threshold select: 1 upper, 0 lower |
| en_wdog | input | 1 | Watchdog pin enable |
| en_alarm | input | 1 | Alarm pin enable |
| en_pwr | input | 1 | Supply-drop pin enable |
| en_bkp_alarm | input | 1 | Alarm pin allowed in backup mode |
| act_high | input | 1 | 1 push-pull active-high, 0 open-drain active-low |
| pulse_mode | input | 1 | 1 timed pulse, 0 level until read |
| backup_mode | input | 1 | Running from backup power |
| cal_mode | input | 1 | Calibration mode |
| sq512 | input | 1 | 512 Hz square wave for calibration output |
| flag_rd | input | 1 | Flag register read strobe |
| flags | output | 4 | {WDF, AF, PF, CF} |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions assume the following about the inputs:
- `tick_32hz`, `tick_1hz`, `wdog_expire` and `century_wrap` are single-cycle strobes.
- The configuration inputs change only between clock edges.
- Hour and date alarm bytes keep bit 6 at 0.

The stimulus drives every input on the falling edge and raises each strobe for exactly one cycle. It builds the 32 Hz tick from a free-running counter and switches modes only while the pin is idle or about to be forced idle, so each mode change is observed from a defined state.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        PIN_IDLE  = 2'd0,
        PIN_PULSE = 2'd1,
        PIN_HOLD  = 2'd2
    } pin_state_e;

    localparam int FLAG_W = 4;
    localparam int FL_CF  = 0;
    localparam int FL_PF  = 1;
    localparam int FL_AF  = 2;
    localparam int FL_WDF = 3;

    localparam int ALM_FIELDS = 4;
    localparam int ALM_VAL_W  = 7;

    typedef struct packed {
        logic                 mask;
        logic [ALM_VAL_W-1:0] val;
    } alarm_byte_t;

endpackage

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp
    import irq_pkg::*;
#(
    parameter int NFIELD  = ALM_FIELDS,
    parameter int FIELD_W = ALM_VAL_W
) (
    input  logic                           tick,
    input  logic [NFIELD-1:0][FIELD_W-1:0] cur_v,
    input  alarm_byte_t [NFIELD-1:0]       alm,
    output logic                           hit
);

    logic [NFIELD-1:0] field_ok;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign field_ok[i] = alm[i].mask || (alm[i].val == cur_v[i]);
    end

    assign hit = tick && (&field_ok);

endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] ev,
    input  logic              flag_rd,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flag_rd ? '0 : flags_q) | ev;
        end
    end

    assign flags = flags_q;

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((flags_q & $past(ev)) == $past(ev)));

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && (ev == '0)) |=> (flags_q == '0));

endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pkg::*;
#(
    parameter int PULSE_TICKS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic pulse_mode,
    input  logic tick_32hz,
    input  logic flag_rd,
    input  logic cal_mode,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_TICKS - 1);

    pin_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cal_mode) begin
            state_d = PIN_IDLE;
            cnt_d   = '0;
        end else if (trig) begin
            state_d = pulse_mode ? PIN_PULSE : PIN_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PIN_IDLE: begin
                    cnt_d = '0;
                end
                PIN_PULSE: begin
                    if (tick_32hz) begin
                        if (cnt_q == CNT_LAST) begin
                            state_d = PIN_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                PIN_HOLD: begin
                    if (flag_rd) state_d = PIN_IDLE;
                end
                default: begin
                    state_d = PIN_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign active = (state_q != PIN_IDLE);

    // R11
    cal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_mode |=> (state_q == PIN_IDLE));

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_HOLD && !flag_rd && !cal_mode && !trig) |=> (state_q == PIN_HOLD));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_PULSE) |-> (cnt_q < CNT_W'(PULSE_TICKS)));

    // R4
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_IDLE && !trig) |=> (state_q == PIN_IDLE));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int PULSE_TICKS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       tick_32hz,
    input  logic [6:0] cur_sec,
    input  logic [6:0] cur_min,
    input  logic [5:0] cur_hour,
    input  logic [5:0] cur_date,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_date,
    input  logic       wdog_expire,
    input  logic       century_wrap,
    input  logic       pwr_cmp_hi,
    input  logic       pwr_cmp_lo,
    input  logic       thr_sel,
    input  logic       en_wdog,
    input  logic       en_alarm,
    input  logic       en_pwr,
    input  logic       en_bkp_alarm,
    input  logic       act_high,
    input  logic       pulse_mode,
    input  logic       backup_mode,
    input  logic       cal_mode,
    input  logic       sq512,
    input  logic       flag_rd,
    output logic [3:0] flags,
    output logic       pin_out,
    output logic       pin_oe
);

    logic [ALM_FIELDS-1:0][ALM_VAL_W-1:0] cur_v;
    alarm_byte_t [ALM_FIELDS-1:0]         alm_v;
    logic                                 alarm_hit;

    assign cur_v[0] = cur_sec;
    assign cur_v[1] = cur_min;
    assign cur_v[2] = {1'b0, cur_hour};
    assign cur_v[3] = {1'b0, cur_date};
    assign alm_v[0] = alm_sec;
    assign alm_v[1] = alm_min;
    assign alm_v[2] = alm_hour;
    assign alm_v[3] = alm_date;

    irq_alarm_cmp #(.NFIELD(ALM_FIELDS), .FIELD_W(ALM_VAL_W)) u_alarm (
        .tick  (tick_1hz),
        .cur_v (cur_v),
        .alm   (alm_v),
        .hit   (alarm_hit)
    );

    logic pwr_sel, pwr_prev_q, pwr_evt, wd_evt;

    assign pwr_sel = thr_sel ? pwr_cmp_hi : pwr_cmp_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_prev_q <= 1'b0;
        else        pwr_prev_q <= pwr_sel;
    end

    assign pwr_evt = pwr_sel && !pwr_prev_q && !backup_mode;
    assign wd_evt  = wdog_expire && !backup_mode;

    logic [FLAG_W-1:0] ev;
    always_comb begin
        ev         = '0;
        ev[FL_WDF] = wd_evt;
        ev[FL_AF]  = alarm_hit;
        ev[FL_PF]  = pwr_evt;
        ev[FL_CF]  = century_wrap;
    end

    irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .flag_rd (flag_rd),
        .flags   (flags)
    );

    logic trig, active;
    assign trig = !cal_mode &&
                  ((wd_evt && en_wdog) ||
                   (pwr_evt && en_pwr) ||
                   (alarm_hit && en_alarm && (!backup_mode || en_bkp_alarm)));

    irq_pin_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .pulse_mode (pulse_mode),
        .tick_32hz  (tick_32hz),
        .flag_rd    (flag_rd),
        .cal_mode   (cal_mode),
        .active     (active)
    );

    always_comb begin
        if (cal_mode) begin
            pin_oe  = 1'b1;
            pin_out = sq512;
        end else if (act_high && !backup_mode) begin
            pin_oe  = 1'b1;
            pin_out = active;
        end else begin
            pin_oe  = active;
            pin_out = 1'b0;
        end
    end

    // R10
    bkp_wdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && !flags[FL_WDF]) |=> !flags[FL_WDF]);

    // R10
    bkp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backup_mode && !cal_mode) |-> !pin_out);

endmodule

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

    localparam int PER = 10;
    localparam int PT  = 7;
    localparam int TICK_DIV = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_1hz = 0, tick_32hz = 0;
    logic [6:0] cur_sec = 0, cur_min = 0;
    logic [5:0] cur_hour = 0, cur_date = 0;
    logic [7:0] alm_sec = 8'h80, alm_min = 8'h80, alm_hour = 8'h80, alm_date = 8'h80;
    logic wdog_expire = 0, century_wrap = 0, pwr_cmp_hi = 0, pwr_cmp_lo = 0, thr_sel = 0;
    logic en_wdog = 0, en_alarm = 0, en_pwr = 0, en_bkp_alarm = 0;
    logic act_high = 0, pulse_mode = 0, backup_mode = 0, cal_mode = 0, sq512 = 0, flag_rd = 0;
    logic [3:0] flags;
    logic pin_out, pin_oe;

    int checks = 0, errors = 0;

    irq_ctrl #(.PULSE_TICKS(PT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_32hz(tick_32hz),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
        .wdog_expire(wdog_expire), .century_wrap(century_wrap),
        .pwr_cmp_hi(pwr_cmp_hi), .pwr_cmp_lo(pwr_cmp_lo), .thr_sel(thr_sel),
        .en_wdog(en_wdog), .en_alarm(en_alarm), .en_pwr(en_pwr), .en_bkp_alarm(en_bkp_alarm),
        .act_high(act_high), .pulse_mode(pulse_mode), .backup_mode(backup_mode),
        .cal_mode(cal_mode), .sq512(sq512), .flag_rd(flag_rd),
        .flags(flags), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(PER/2) clk = ~clk;

    int tdiv = 0;
    int sqdiv = 0;
    always @(negedge clk) begin
        tdiv  = (tdiv + 1) % TICK_DIV;
        tick_32hz <= (tdiv == 0);
        sqdiv = (sqdiv + 1) % 4;
        if (sqdiv == 0) sq512 <= ~sq512;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_flags = 0, m_state = 0, m_cnt = 0;
    bit  m_prev = 0;
    always @(posedge clk) begin
        bit sel, wd, pf, al, trig;
        bit exp_oe, exp_out, act;
        if (!rst_n) begin
            m_flags = 0; m_state = 0; m_cnt = 0; m_prev = 0;
        end else begin
            sel = thr_sel ? pwr_cmp_hi : pwr_cmp_lo;
            wd  = wdog_expire && !backup_mode;
            pf  = sel && !m_prev && !backup_mode;
            m_prev = sel;
            al  = tick_1hz &&
                  (alm_sec[7]  || alm_sec[6:0]  == cur_sec) &&
                  (alm_min[7]  || alm_min[6:0]  == cur_min) &&
                  (alm_hour[7] || alm_hour[6:0] == {1'b0, cur_hour}) &&
                  (alm_date[7] || alm_date[6:0] == {1'b0, cur_date});
            trig = !cal_mode && ((wd && en_wdog) || (pf && en_pwr) ||
                   (al && en_alarm && (!backup_mode || en_bkp_alarm)));
            if (flag_rd) m_flags = 0;
            if (wd) m_flags |= 8;
            if (al) m_flags |= 4;
            if (pf) m_flags |= 2;
            if (century_wrap) m_flags |= 1;
            if (cal_mode) begin m_state = 0; m_cnt = 0; end
            else if (trig) begin m_state = pulse_mode ? 1 : 2; m_cnt = 0; end
            else if (m_state == 1 && tick_32hz) begin
                if (m_cnt == PT - 1) begin m_state = 0; m_cnt = 0; end
                else m_cnt++;
            end else if (m_state == 2 && flag_rd) m_state = 0;
        end
        #(PER/4);
        act = (m_state != 0);
        if (cal_mode) begin exp_oe = 1; exp_out = sq512; end
        else if (act_high && !backup_mode) begin exp_oe = 1; exp_out = act; end
        else begin exp_oe = act; exp_out = 0; end
        check("R2 R3 R8 R9 R10 flags", int'(flags), m_flags);
        check("R4 R5 R6 R7 R11 pin_oe", int'(pin_oe), int'(exp_oe));
        check("R4 R5 R6 R10 R11 pin_out", int'(pin_out), int'(exp_out));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_flags();
        flag_rd = 1; cyc(1); flag_rd = 0; cyc(1);
    endtask

    initial begin
        #(PER * 150000);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1
        check("R1 reset flags", int'(flags), 0);
        check("R1 reset pin_oe", int'(pin_oe), 0);

        // R4 disabled source: flag only
        wdog_expire = 1; cyc(1); wdog_expire = 0; cyc(1);
        check("R2 wdf set", int'(flags[3]), 1);
        check("R4 disabled no pin", int'(pin_oe), 0);
        read_flags();
        check("R3 cleared", int'(flags), 0);

        // R7 level mode, open drain
        en_wdog = 1; en_alarm = 1; en_pwr = 1;
        wdog_expire = 1; century_wrap = 1; cyc(1); wdog_expire = 0; century_wrap = 0;
        cyc(20);
        check("R7 level held oe", int'(pin_oe), 1);
        check("R5 open drain out", int'(pin_out), 0);
        check("R2 wdf cf", int'(flags), 9);
        read_flags();
        check("R7 released", int'(pin_oe), 0);

        // R3 read with simultaneous event
        century_wrap = 1; flag_rd = 1; cyc(1); century_wrap = 0; flag_rd = 0; cyc(1);
        check("R3 event wins", int'(flags), 1);
        read_flags();

        // R6 pulse mode push-pull, alarm with masks
        pulse_mode = 1; act_high = 1;
        cur_sec = 7'h42; cur_min = 7'h17; cur_hour = 6'h09; cur_date = 6'h21;
        alm_sec = 8'h42; alm_min = 8'h17; alm_hour = 8'h80; alm_date = 8'h21;
        tick_1hz = 1; cyc(1); tick_1hz = 0;
        check("R8 alarm hit", int'(flags[2]), 1);
        check("R6 pulse active", int'(pin_out), 1);
        cyc(PT * TICK_DIV - TICK_DIV - 2);
        check("R6 still active", int'(pin_out), 1);
        cyc(2 * TICK_DIV);
        check("R6 ended", int'(pin_out), 0);
        read_flags();

        // R8 unmasked mismatch
        alm_sec = 8'h43;
        tick_1hz = 1; cyc(1); tick_1hz = 0; cyc(1);
        check("R8 mismatch", int'(flags[2]), 0);
        alm_sec = 8'h80; alm_min = 8'h80; alm_date = 8'h80;
        cyc(2);
        // R8 no tick: no match
        cyc(3);
        check("R8 needs tick", int'(flags[2]), 0);

        // R6 retrigger
        wdog_expire = 1; cyc(1); wdog_expire = 0;
        cyc(4 * TICK_DIV);
        wdog_expire = 1; cyc(1); wdog_expire = 0;
        cyc(5 * TICK_DIV);
        check("R6 retrigger extends", int'(pin_out), 1);
        cyc(3 * TICK_DIV);
        check("R6 retrigger end", int'(pin_out), 0);
        read_flags();

        // R9 threshold select
        thr_sel = 1; pwr_cmp_lo = 1; cyc(3);
        check("R9 other comparator ignored", int'(flags[1]), 0);
        pwr_cmp_hi = 1; cyc(2);
        check("R9 selected edge", int'(flags[1]), 1);
        cyc(PT * TICK_DIV + TICK_DIV);
        pwr_cmp_hi = 0; pwr_cmp_lo = 0; cyc(2);
        read_flags();

        // R10 backup mode
        backup_mode = 1; pulse_mode = 0;
        wdog_expire = 1; pwr_cmp_hi = 1; cyc(1); wdog_expire = 0; cyc(2);
        check("R10 wdog/pf ignored", int'(flags), 0);
        check("R10 no pin", int'(pin_oe), 0);
        tick_1hz = 1; cyc(1); tick_1hz = 0; cyc(1);
        check("R10 alarm needs backup enable", int'(pin_oe), 0);
        en_bkp_alarm = 1;
        tick_1hz = 1; cyc(1); tick_1hz = 0; cyc(1);
        check("R10 alarm drives low oe", int'(pin_oe), 1);
        check("R10 alarm drives low out", int'(pin_out), 0);
        read_flags();
        backup_mode = 0; pwr_cmp_hi = 0; cyc(2);

        // R11 calibration
        cal_mode = 1; cyc(1);
        wdog_expire = 1; cyc(1); wdog_expire = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            check("R11 pin follows 512", int'(pin_out), int'(sq512));
        end
        check("R11 oe driven", int'(pin_oe), 1);
        check("R11 flag still latched", int'(flags[3]), 1);
        cal_mode = 0; cyc(2);
        check("R11 no trigger kept", int'(pin_out), 0);
        read_flags();
        cyc(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule